// File: doc/BRIEF.md
# Staged Power-On Reset Sequencer

The block turns one power-good input and a slow tick, derived inside the block from the system clock, into a set of active-low resets and enables that release in a fixed order. The first stage frees the peripheral/codec reset and the UART reset together, and it also drops the interrupt-timer clear. The second stage frees the CPU reset and, in the same cycle, enables the display and output registers. The third stage lifts the audio mute.

A drop of power-good, or of the system reset, clears every stage asynchronously at once. Each later release is synchronous and takes a parameterised number of slow ticks after the stage before it. The mute stage advances only on ticks while a CPU-driven gate input is low. The gate is low after reset, so the mute lifts two ticks after the CPU starts unless the CPU raises the gate first. With the gate high, the mute lifts on the first EEPROM write strobe after the CPU reset has released. It also lifts if the gate then stays low for two whole ticks.

Top module: `staged_por_seq`

## Requirements
- R1: While pwr_ok_i is low, every reset and mute output is asserted: *_rst_no, mute_no and disp_en_no are high or low as for reset (resets 0, disp_en_no 1, tmr_clr_o 1). The outputs go to this state without waiting for a clock edge when pwr_ok_i falls.
- R2: periph_rst_no and uart_rst_no rise in the same cycle. That cycle lies on the DLY_IO-th tick after the two-flop-synchronised power-good turns high, which is 2+(DLY_IO-1)*TICK_DIV+1 to 2+DLY_IO*TICK_DIV clock edges after pwr_ok_i rises.
- R3: tmr_clr_o is high exactly while uart_rst_no is low.
- R4: cpu_rst_no rises exactly DLY_CPU*TICK_DIV clock cycles after uart_rst_no rises.
- R5: disp_en_no falls in the same cycle that cpu_rst_no rises, and stays the inverse of cpu_rst_no.
- R6: No stage releases before the stage ahead of it. The order is periph/UART, then CPU with the display enable, then mute.
- R7: With mute_gate_i low, mute_no rises exactly MUTE_TICKS*TICK_DIV cycles after cpu_rst_no rises.
- R8: While mute_gate_i is high, ticks do not advance the mute stage. A low spell on mute_gate_i that covers fewer than MUTE_TICKS ticks is forgotten when the gate goes high again.
- R9: After cpu_rst_no has risen, a rising edge on eep_wr_i makes mute_no rise within 4 clock edges. An edge that arrives while cpu_rst_no is still low is ignored.
- R10: rst_ni low clears all stages asynchronously, with the same output state as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| pwr_ok_i | input | 1 | Asynchronous power-good; low clears all stages |
| mute_gate_i | input | 1 | CPU gate; high blocks ticks to the mute stage |
| eep_wr_i | input | 1 | EEPROM write strobe, asynchronous |
| periph_rst_no | output | 1 | Peripheral/codec reset, active low |
| uart_rst_no | output | 1 | UART reset, active low |
| tmr_clr_o | output | 1 | Interrupt-timer clear, active high |
| cpu_rst_no | output | 1 | CPU reset, active low |
| disp_en_no | output | 1 | Display/output-register enable, active low |
| mute_no | output | 1 | Audio mute, active low (high = released) |

## Verification
The assertions assume that mute_gate_i comes from a register in the clock domain and changes only away from the clock edge. They also assume that rst_ni is applied together with power-good low at start-up, so that the spacing counter starts from a cleared chain. The bench drives every input half a cycle or a fixed delay after a rising edge. It holds pulses on eep_wr_i across at least one rising edge, so the synchroniser captures each one. It drops power-good in the middle of a cycle to check that the clear does not depend on the clock.

// File: rtl/staged_por_pkg.sv
package staged_por_pkg;
  localparam int NUM_TIMED = 2;
  typedef enum int {ST_IO = 0, ST_CPU = 1} stage_e;
endpackage

// File: rtl/por_sync_2ff.sv
module por_sync_2ff (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      meta_q <= 1'b0;
      q_o    <= 1'b0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/por_tick_div.sv
module por_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == CW'(DIV - 1));
      cnt_q  <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/por_stage_timer.sv
module por_stage_timer #(
  parameter int DLY = 8
) (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic tick_i,
  input  logic en_i,
  output logic rel_o
);
  localparam int CW = $clog2(DLY + 1);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      cnt_q <= '0;
      rel_o <= 1'b0;
    end else if (en_i && !rel_o && tick_i) begin
      if (cnt_q == CW'(DLY - 1)) rel_o <= 1'b1;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/por_mute_stage.sv
module por_mute_stage #(
  parameter int LOW_TICKS = 2
) (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic tick_i,
  input  logic arm_i,
  input  logic gate_i,
  input  logic eep_wr_i,
  output logic rel_o
);
  localparam int CW = $clog2(LOW_TICKS + 1);
  logic [CW-1:0] low_cnt_q;
  logic          eep_q;
  logic          eep_rise;

  assign eep_rise = eep_wr_i & ~eep_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      low_cnt_q <= '0;
      eep_q     <= 1'b0;
      rel_o     <= 1'b0;
    end else begin
      eep_q <= eep_wr_i;
      if (!arm_i || gate_i) begin
        low_cnt_q <= '0;
      end else if (tick_i && !rel_o) begin
        if (low_cnt_q == CW'(LOW_TICKS - 1)) rel_o <= 1'b1;
        else                                 low_cnt_q <= low_cnt_q + 1'b1;
      end
      if (arm_i && eep_rise) rel_o <= 1'b1;
    end
  end
endmodule

// File: rtl/staged_por_seq.sv
module staged_por_seq
  import staged_por_pkg::*;
#(
  parameter int TICK_DIV   = 4,
  parameter int DLY_IO     = 23,
  parameter int DLY_CPU    = 7,
  parameter int MUTE_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  input  logic mute_gate_i,
  input  logic eep_wr_i,
  output logic periph_rst_no,
  output logic uart_rst_no,
  output logic tmr_clr_o,
  output logic cpu_rst_no,
  output logic disp_en_no,
  output logic mute_no
);
  localparam int STAGE_DLY [NUM_TIMED] = '{DLY_IO, DLY_CPU};

  logic clear_n;
  logic pwr_sync;
  logic eep_sync;
  logic tick;
  logic [NUM_TIMED:0] stage_en;
  logic [NUM_TIMED-1:0] stage_rel;
  logic mute_rel;

  // assertion is asynchronous, release is synchronous
  assign clear_n = rst_ni & pwr_ok_i;

  por_sync_2ff u_pwr_sync (.clk_i(clk_i), .clr_ni(clear_n), .d_i(1'b1),     .q_o(pwr_sync));
  por_sync_2ff u_eep_sync (.clk_i(clk_i), .clr_ni(clear_n), .d_i(eep_wr_i), .q_o(eep_sync));

  por_tick_div #(.DIV(TICK_DIV)) u_tick (.clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  assign stage_en[0] = pwr_sync;

  for (genvar g = 0; g < NUM_TIMED; g++) begin : g_stage
    por_stage_timer #(.DLY(STAGE_DLY[g])) u_stage (
      .clk_i (clk_i),
      .clr_ni(clear_n),
      .tick_i(tick),
      .en_i  (stage_en[g]),
      .rel_o (stage_rel[g])
    );
    assign stage_en[g+1] = stage_rel[g];
  end

  por_mute_stage #(.LOW_TICKS(MUTE_TICKS)) u_mute (
    .clk_i   (clk_i),
    .clr_ni  (clear_n),
    .tick_i  (tick),
    .arm_i   (stage_en[NUM_TIMED]),
    .gate_i  (mute_gate_i),
    .eep_wr_i(eep_sync),
    .rel_o   (mute_rel)
  );

  assign periph_rst_no = stage_rel[ST_IO];
  assign uart_rst_no   = stage_rel[ST_IO];
  assign tmr_clr_o     = ~stage_rel[ST_IO];
  assign cpu_rst_no    = stage_rel[ST_CPU];
  assign disp_en_no    = ~stage_rel[ST_CPU];
  assign mute_no       = mute_rel;
endmodule

// File: rtl/staged_por_chk.sv
module staged_por_chk #(
  parameter int TICK_DIV = 4,
  parameter int DLY_CPU  = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_ok_i,
  input logic periph_rst_no,
  input logic uart_rst_no,
  input logic tmr_clr_o,
  input logic cpu_rst_no,
  input logic disp_en_no,
  input logic mute_no
);
  localparam int GAP = DLY_CPU * TICK_DIV;
  int unsigned since_io_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           since_io_q <= 0;
    else if (!uart_rst_no) since_io_q <= 0;
    else if (since_io_q < GAP) since_io_q <= since_io_q + 1;
  end

  AST_ALL_HELD_PWR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |-> (!periph_rst_no && !uart_rst_no && tmr_clr_o && !cpu_rst_no && disp_en_no && !mute_no)); // R1
  AST_IO_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_rst_no == uart_rst_no); // R2
  AST_TMR_CLR_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_clr_o == !uart_rst_no); // R3
  AST_CPU_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_no) |-> since_io_q >= GAP - 1); // R4
  AST_DISP_WITH_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_en_no == !cpu_rst_no); // R5
  AST_CPU_AFTER_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_no) |-> uart_rst_no); // R6
  AST_MUTE_AFTER_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mute_no) |-> cpu_rst_no); // R6
endmodule

bind staged_por_seq staged_por_chk #(.TICK_DIV(TICK_DIV), .DLY_CPU(DLY_CPU)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_ok_i(pwr_ok_i),
  .periph_rst_no(periph_rst_no), .uart_rst_no(uart_rst_no), .tmr_clr_o(tmr_clr_o),
  .cpu_rst_no(cpu_rst_no), .disp_en_no(disp_en_no), .mute_no(mute_no)
);

// File: tb/tb_staged_por_seq.sv
`timescale 1ns/1ps
module tb_staged_por_seq;
  localparam int TD = 4, D_IO = 23, D_CPU = 7, MT = 2;

  logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b0, gate = 1'b0, eep = 1'b0;
  logic periph_rst_n, uart_rst_n, tmr_clr, cpu_rst_n, disp_en_n, mute_n;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  staged_por_seq #(.TICK_DIV(TD), .DLY_IO(D_IO), .DLY_CPU(D_CPU), .MUTE_TICKS(MT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .mute_gate_i(gate), .eep_wr_i(eep),
    .periph_rst_no(periph_rst_n), .uart_rst_no(uart_rst_n), .tmr_clr_o(tmr_clr),
    .cpu_rst_no(cpu_rst_n), .disp_en_no(disp_en_n), .mute_no(mute_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic logic [5:0] outs();
    return {periph_rst_n, uart_rst_n, tmr_clr, cpu_rst_n, disp_en_n, mute_n};
  endfunction
  localparam logic [5:0] ALL_HELD = 6'b001010;

  // count rising edges until the selected output releases
  task automatic wait_rel(input int sel, output int n);
    n = 0;
    do begin
      @(posedge clk); n++; #1;
    end while (!((sel == 0 && uart_rst_n) || (sel == 1 && cpu_rst_n) || (sel == 2 && mute_n)) && n < 2000);
  endtask

  task automatic power_up();
    @(posedge clk); #1; pwr_ok = 1'b1;
  endtask

  task automatic power_down();
    @(posedge clk); #1; pwr_ok = 1'b0; gate = 1'b0; eep = 1'b0;
    repeat (3) @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R10 outputs under rst_ni", outs(), ALL_HELD);
    rst_n = 1'b1;
    repeat (5) @(posedge clk); #1;
    chk("R1 outputs while pwr low", outs(), ALL_HELD);
    chk("R3 timer clear in reset", tmr_clr, 1);
  endtask

  task automatic t_sequence();
    int n;
    gate = 1'b0;
    power_up();
    wait_rel(0, n);
    chk_rng("R2 io release delay", n, 2 + (D_IO - 1) * TD + 1, 2 + D_IO * TD);
    chk("R2 periph with uart", periph_rst_n, 1);
    chk("R3 timer clear dropped", tmr_clr, 0);
    chk("R6 cpu held at io release", cpu_rst_n, 0);
    wait_rel(1, n);
    chk("R4 cpu spacing", n, D_CPU * TD);
    chk("R5 display enable with cpu", disp_en_n, 0);
    chk("R6 mute held at cpu release", mute_n, 0);
    wait_rel(2, n);
    chk("R7 mute spacing gate low", n, MT * TD);
  endtask

  task automatic t_drop_mid();
    int n;
    power_down();
    power_up();
    wait_rel(0, n);
    repeat (3) @(posedge clk);
    #1.3 pwr_ok = 1'b0;
    #0.4;
    chk("R1 async clear on drop", outs(), ALL_HELD);
    repeat (2) @(posedge clk); #1;
    chk("R1 held after drop", outs(), ALL_HELD);
  endtask

  task automatic t_gate_eep();
    int n;
    power_down();
    gate = 1'b1;
    power_up();
    wait_rel(1, n);
    repeat (10 * TD) @(posedge clk); #1;
    chk("R8 gate high blocks mute", mute_n, 0);
    gate = 1'b0;
    repeat (TD) @(posedge clk);
    #1 gate = 1'b1;
    repeat (10 * TD) @(posedge clk); #1;
    chk("R8 short low spell forgotten", mute_n, 0);
    eep = 1'b1;
    @(posedge clk); #1 eep = 1'b0;
    n = 1;
    while (!mute_n && n < 20) begin @(posedge clk); n++; #1; end
    chk_rng("R9 eep write releases mute", n, 1, 4);
  endtask

  task automatic t_eep_early();
    int n;
    power_down();
    gate = 1'b1;
    power_up();
    repeat (20) @(posedge clk);
    #1 eep = 1'b1;
    repeat (2) @(posedge clk);
    #1 eep = 1'b0;
    wait_rel(1, n);
    repeat (5 * TD) @(posedge clk); #1;
    chk("R9 early eep write ignored", mute_n, 0);
  endtask

  task automatic t_sys_reset();
    int n;
    power_down();
    gate = 1'b0;
    power_up();
    wait_rel(2, n);
    chk("R7 released before reset test", mute_n, 1);
    #1.2 rst_n = 1'b0;
    #0.4;
    chk("R10 async clear on rst_ni", outs(), ALL_HELD);
    @(posedge clk); #1 rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_sequence();
    t_drop_mid();
    t_gate_eep();
    t_eep_early();
    t_sys_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule